// File: doc/BRIEF.md
# Branch Target Address Generator

This unit works out the next program counter for control-transfer instructions in a 16-bit code address space. Each request carries the PC of the instruction, its length in bytes, the opcode byte, up to two operand bytes, the accumulator, the data pointer, a transfer kind and a condition bit. The condition bit is worked out elsewhere. One clock later the unit returns the next PC and a taken flag. The flag separates a redirect from plain fall-through.

Five kinds of transfer are supported:

- **Page-absolute:** the target is spliced from the upper bits of the already-advanced PC, three opcode bits and one operand byte.
- **Long:** a full 16-bit target comes from two operand bytes.
- **Unconditional relative:** a signed byte offset is added to the address after the instruction.
- **Conditional relative:** as the unconditional form, but only when the condition bit is set.
- **Indirect:** the data pointer plus the accumulator.

A sequential kind returns the fall-through address. Fetch, stack traffic and flag evaluation are outside this unit.

Top module: `bta_gen`

## Requirements
- R1: While reset is held, and on the first edge after it, `resValid`, `resTaken` and `resPc` are all 0.
- R2: A result is registered on the rising edge where `reqValid` is 1. `resValid` is 1 for exactly the cycle after each such edge. On an edge with `reqValid` 0, `resPc` and `resTaken` keep their values.
- R3: For kind 1 (page-absolute), let inc = `pc` + `instLen`. The target has the following parts:
  - bits 15..11 are inc[15..11];
  - bits 10..8 are `opcode`[7..5];
  - bits 7..0 are `byte1`.
  `resTaken` is 1. The target lies in the 2 KB block of inc, which may differ from the block of `pc`.
- R4: For kind 2 (long), the target is {`byte1`,`byte2`}, with `byte1` as the high byte, and `resTaken` is 1.
- R5: For kind 3 (unconditional relative), the target is inc plus the sign-extended offset byte, and `resTaken` is 1. The offset byte is the last byte of the instruction: `byte2` when `instLen` is 3, otherwise `byte1`. Its range is -128 to +127.
- R6: For kind 4 (conditional relative), the R5 target is used when `cond` is 1, and `resTaken` equals `cond`. When `cond` is 0, `resPc` is inc. This covers 3-byte compare-and-branch, where inc is `pc`+3.
- R7: For kind 5 (indirect), the target is `dptr` + zero-extended `acc`, modulo 2^16, and `resTaken` is 1.
- R8: Kind 0 (sequential) and the unused kinds 6 and 7 give `resPc` = inc and `resTaken` = 0.
- R9: All address sums wrap modulo 2^16. This applies to inc, the relative target and the indirect target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe |
| kind | input | 3 | Transfer kind: 0 seq, 1 page, 2 long, 3 rel, 4 cond rel, 5 indirect |
| pc | input | 16 | Address of the instruction's first byte |
| instLen | input | 2 | Instruction length in bytes, 1 to 3 |
| opcode | input | 8 | Opcode byte |
| byte1 | input | 8 | Second instruction byte |
| byte2 | input | 8 | Third instruction byte |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| cond | input | 1 | Branch condition for kind 4 |
| resValid | output | 1 | Result strobe |
| resPc | output | 16 | Next program counter |
| resTaken | output | 1 | Control transfer taken |

## Verification
Every result is due exactly one rising edge after the edge that samples `reqValid`. No other stage lies between the inputs and the output register.

The bench drives each request on a falling edge and lets the next rising edge capture it. It compares `resPc`, `resTaken` and `resValid` at the following falling edge. For the hold rule, it changes all inputs with `reqValid` low and checks one edge later that the previous result is unchanged.

// File: rtl/bta_pkg.sv
package bta_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    KIND_SEQ  = 3'd0,
    KIND_PAGE = 3'd1,
    KIND_LONG = 3'd2,
    KIND_REL  = 3'd3,
    KIND_CREL = 3'd4,
    KIND_IND  = 3'd5
  } kind_e;

  typedef struct packed {
    logic load;
    logic selPage;
    logic selLong;
    logic selRel;
    logic selInd;
    logic take;
    logic offHigh;
  } strobe_t;
endpackage

// File: rtl/bta_ctrl.sv
module bta_ctrl
  import bta_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  input  logic [2:0]    kind,
  input  logic [1:0]    instLen,
  input  logic          cond,
  output strobe_t       strobes
);
  always_comb begin
    strobes         = '0;
    strobes.load    = reqValid;
    strobes.offHigh = (instLen == 2'd3);
    case (kind)
      KIND_PAGE: begin strobes.selPage = 1'b1; strobes.take = 1'b1; end
      KIND_LONG: begin strobes.selLong = 1'b1; strobes.take = 1'b1; end
      KIND_REL:  begin strobes.selRel  = 1'b1; strobes.take = 1'b1; end
      KIND_CREL: begin strobes.selRel  = cond; strobes.take = cond; end
      KIND_IND:  begin strobes.selInd  = 1'b1; strobes.take = 1'b1; end
      default:   ;
    endcase
  end

  // At most one target source may be chosen (R8: none for sequential kinds)
  assert_single_source_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.selPage, strobes.selLong, strobes.selRel, strobes.selInd}));

  // A selected target source always means a taken transfer (R6)
  assert_select_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (strobes.selPage | strobes.selLong | strobes.selRel | strobes.selInd) |-> strobes.take);
endmodule

// File: rtl/bta_dpath.sv
module bta_dpath
  import bta_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       strobes,
  input  logic [AW-1:0] pc,
  input  logic [1:0]    instLen,
  input  logic [BW-1:0] opcode,
  input  logic [BW-1:0] byte1,
  input  logic [BW-1:0] byte2,
  input  logic [BW-1:0] acc,
  input  logic [AW-1:0] dptr,
  output logic          resValid,
  output logic [AW-1:0] resPc,
  output logic          resTaken
);
  localparam int PAGE_BITS = BW + 3;

  logic [AW-1:0] incPc, relTgt, pageTgt, longTgt, indTgt, target;
  logic [BW-1:0] relOff;

  assign incPc   = pc + AW'(instLen);
  assign relOff  = strobes.offHigh ? byte2 : byte1;
  assign relTgt  = incPc + {{(AW-BW){relOff[BW-1]}}, relOff};
  assign pageTgt = {incPc[AW-1:PAGE_BITS], opcode[BW-1:BW-3], byte1};
  assign longTgt = AW'({byte1, byte2});
  assign indTgt  = dptr + {{(AW-BW){1'b0}}, acc};

  always_comb begin
    target = incPc;
    if (strobes.selPage) target = pageTgt;
    if (strobes.selLong) target = longTgt;
    if (strobes.selRel)  target = relTgt;
    if (strobes.selInd)  target = indTgt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      resPc    <= '0;
      resTaken <= 1'b0;
    end else begin
      resValid <= strobes.load;
      if (strobes.load) begin
        resPc    <= target;
        resTaken <= strobes.take;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> resValid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> ($stable(resPc) && $stable(resTaken) && !resValid));
  assert_page_block_R3: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && strobes.selPage) |=> (resPc[AW-1:PAGE_BITS] == $past(incPc[AW-1:PAGE_BITS])));
  assert_long_target_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && strobes.selLong) |=> (resPc == $past(AW'({byte1, byte2}))));
  assert_fallthrough_R6: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && !strobes.take) |=> (resPc == $past(pc + AW'(instLen)) && !resTaken));
endmodule

// File: rtl/bta_gen.sv
module bta_gen
  import bta_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic [2:0]  kind,
  input  logic [15:0] pc,
  input  logic [1:0]  instLen,
  input  logic [7:0]  opcode,
  input  logic [7:0]  byte1,
  input  logic [7:0]  byte2,
  input  logic [7:0]  acc,
  input  logic [15:0] dptr,
  input  logic        cond,
  output logic        resValid,
  output logic [15:0] resPc,
  output logic        resTaken
);
  strobe_t strobes;

  bta_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .kind(kind),
    .instLen(instLen), .cond(cond), .strobes(strobes)
  );

  bta_dpath #(.AW(16), .BW(8)) u_dpath (
    .clk(clk), .rst(rst), .strobes(strobes), .pc(pc), .instLen(instLen),
    .opcode(opcode), .byte1(byte1), .byte2(byte2), .acc(acc), .dptr(dptr),
    .resValid(resValid), .resPc(resPc), .resTaken(resTaken)
  );

  // R1: outputs stay cleared on the edge after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!resValid && resPc == 16'h0 && !resTaken));
endmodule

// File: tb/tb_bta_gen.sv
module tb_bta_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, reqValid = 1'b0, cond = 1'b0;
  logic [2:0] kind = '0;
  logic [15:0] pc = '0, dptr = '0;
  logic [1:0] instLen = 2'd1;
  logic [7:0] opcode = '0, byte1 = '0, byte2 = '0, acc = '0;
  logic resValid, resTaken;
  logic [15:0] resPc;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bta_gen dut (.*);

  function automatic logic [16:0] model(input logic [2:0] k, input logic [15:0] p,
      input logic [1:0] l, input logic [7:0] op, b1, b2, a, input logic [15:0] dp,
      input logic c);
    logic [15:0] inc, rel;
    logic [7:0] off;
    inc = p + {14'd0, l};
    off = (l == 2'd3) ? b2 : b1;
    rel = inc + {{8{off[7]}}, off};
    case (k)
      3'd1: return {1'b1, inc[15:11], op[7:5], b1};
      3'd2: return {1'b1, b1, b2};
      3'd3: return {1'b1, rel};
      3'd4: return c ? {1'b1, rel} : {1'b0, inc};
      3'd5: return {1'b1, dp + {8'd0, a}};
      default: return {1'b0, inc};
    endcase
  endfunction

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input string req, input logic [2:0] k, input logic [15:0] p,
      input logic [1:0] l, input logic [7:0] op, b1, b2, a, input logic [15:0] dp,
      input logic c);
    logic [16:0] exp;
    @(negedge clk);
    reqValid = 1; kind = k; pc = p; instLen = l; opcode = op;
    byte1 = b1; byte2 = b2; acc = a; dptr = dp; cond = c;
    exp = model(k, p, l, op, b1, b2, a, dp, c);
    @(negedge clk);
    reqValid = 0;
    check({req, " valid"}, {16'd0, resValid}, 17'd1);
    check(req, {resTaken, resPc}, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {resValid, resTaken, resPc}, 18'd0);
    rst = 0;
    @(negedge clk);
    check("R1 after", {resValid, resTaken, resPc}, 18'd0);

    issue("R3 example",   3'd1, 16'h0343, 2'd2, 8'h21, 8'h23, 8'h00, 8'h00, 16'h0, 0);
    issue("R3 block edge",3'd1, 16'h07FE, 2'd2, 8'hE1, 8'h00, 8'h00, 8'h00, 16'h0, 0);
    issue("R4 long",      3'd2, 16'h1234, 2'd3, 8'h02, 8'hBE, 8'hEF, 8'h00, 16'h0, 0);
    issue("R5 R9 wrap",   3'd3, 16'hFFFE, 2'd2, 8'h80, 8'h05, 8'h00, 8'h00, 16'h0, 0);
    issue("R5 neg len3",  3'd3, 16'h0010, 2'd3, 8'hB4, 8'h11, 8'h80, 8'h00, 16'h0, 0);
    issue("R6 not taken", 3'd4, 16'h0100, 2'd3, 8'hB4, 8'h11, 8'h40, 8'h00, 16'h0, 0);
    issue("R6 taken",     3'd4, 16'h0100, 2'd3, 8'hB4, 8'h11, 8'h7F, 8'h00, 16'h0, 1);
    issue("R7 R9 wrap",   3'd5, 16'h0200, 2'd1, 8'h73, 8'h00, 8'h00, 8'h20, 16'hFFF0, 0);
    issue("R8 seq",       3'd0, 16'hFFFF, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0, 1);
    issue("R8 unused",    3'd7, 16'h4000, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0, 1);

    // R2 hold: inputs change with reqValid low; previous result must remain
    begin
      logic [16:0] prev;
      prev = {resTaken, resPc};
      kind = 3'd2; byte1 = 8'h55; byte2 = 8'hAA; pc = 16'h9999;
      @(negedge clk);
      check("R2 hold", {resTaken, resPc}, prev);
      check("R2 valid low", {16'd0, resValid}, 17'd0);
    end

    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      logic [2:0] k;
      logic [1:0] l;
      k = 3'($urandom_range(0, 7));
      l = 2'($urandom_range(1, 3));
      issue("R9 random", k, 16'($urandom), l, 8'($urandom), 8'($urandom),
            8'($urandom), 8'($urandom), 16'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule